// File: doc/BRIEF.md
# Multimode Counter and Bidirectional Shift Register

This block is a small register, four bits wide by default, whose next value is chosen each clock by a 3-bit operation code. It can count up or down with wrap-around, shift in either direction, take a parallel value, invert itself, clear itself or hold. An active-high reset input clears the register immediately, whatever the clock and the other inputs are doing. The register drives a true output and a complemented output.

A single active-low terminal output lets several stages act as one wider register. In the count modes it marks the carry or borrow point. In the shift modes it carries the top data bit. On the next stage up, one input has two jobs. It is the active-low trickle enable when counting, and the serial input when shifting toward the MSB. So one wire per stage boundary serves both counting and shifting toward the MSB. All stages share the clock, the operation code and the parallel enable. For shifts toward the LSB, each stage's bit 0 is wired to the serial input of the stage below.

Top module: `mode_counter_shifter`

## Requirements
- R1: The operation code `op_sel` decodes as follows: 0 = parallel load, 1 = complement, 2 = shift toward LSB, 3 = shift toward MSB, 4 = count down, 5 = clear, 6 = count up, 7 = hold. All of these take effect on the rising clock edge.
- R2: While `mrst` is high, `q` is 0 without waiting for a clock edge. In that state, clock edges and all other inputs have no effect.
- R3: Parallel load (code 0) copies `preset` into `q`.
- R4: Complement (code 1) replaces `q` with its bitwise inverse.
- R5: Shift toward LSB (code 2) makes `q` = {`ser_lsb`, q[W-1:1]}.
- R6: Shift toward MSB (code 3) makes `q` = {q[W-2:0], `trickle_n`}. In this mode `trickle_n` is the serial data input.
- R7: Count up (code 6) adds 1 modulo 2^W when `par_en_n` and `trickle_n` are both 0. Count down (code 4) subtracts 1 modulo 2^W under the same condition.
- R8: In either count mode, if `par_en_n` or `trickle_n` is 1, `q` keeps its value.
- R9: In count up, `term_n` is 0 exactly when `trickle_n` is 0 and `q` is all ones. In count down, `term_n` is 0 exactly when `trickle_n` is 0 and `q` is 0. In every other case in the count modes, `term_n` is 1. `par_en_n` has no effect on `term_n`.
- R10: In both shift modes, `term_n` equals q[W-1] combinationally.
- R11: In load, complement, clear and hold, `term_n` is 1.
- R12: Clear (code 5) sets `q` to 0. Hold (code 7) keeps `q`.
- R13: `q_n` is always the bitwise inverse of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mrst | input | 1 | Asynchronous clear, active high |
| op_sel | input | 3 | Operation code |
| preset | input | W | Parallel load value |
| par_en_n | input | 1 | Parallel count enable, active low |
| trickle_n | input | 1 | Trickle count enable (active low), and the serial input for shifts toward the MSB |
| ser_lsb | input | 1 | Serial input for shifts toward the LSB |
| q | output | W | Register contents |
| q_n | output | W | Inverted register contents |
| term_n | output | 1 | Terminal count (active low), or q[W-1] in the shift modes |

## Verification
On every cycle, the assertions check the following:
- the asynchronous clear;
- the inverse output;
- the hold and clear codes, and the complement code;
- the frozen value in a count mode when an enable is off;
- the terminal output in every mode group.

The exact arithmetic, the direction of each shift, the serial inputs and the wrap at both ends are checked against the bench's reference functions over random and directed sequences. Only the bench's two-stage scenarios can show that the single link between stages carries the carry, the borrow and the shifted bit correctly across an 8-bit value.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_INVERT = 3'd1,
        OP_TO_LSB = 3'd2,
        OP_TO_MSB = 3'd3,
        OP_DOWN   = 3'd4,
        OP_CLEAR  = 3'd5,
        OP_UP     = 3'd6,
        OP_HOLD   = 3'd7
    } mcs_op_e;
endpackage

// File: rtl/mcs_next.sv
`timescale 1ns/1ps
module mcs_next
    import mcs_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mcs_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    input  logic             par_en_n,
    input  logic             trickle_n,
    input  logic             ser_lsb,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
    logic go;

    assign go = ~(par_en_n | trickle_n);

    always_comb begin
        nxt = cur;
        case (op)
            OP_LOAD:   nxt = preset;
            OP_INVERT: nxt = ~cur;
            OP_TO_LSB: nxt = {ser_lsb, cur[WIDTH-1:1]};
            OP_TO_MSB: nxt = {cur[WIDTH-2:0], trickle_n};
            OP_DOWN:   nxt = go ? cur - ONE : cur;
            OP_CLEAR:  nxt = '0;
            OP_UP:     nxt = go ? cur + ONE : cur;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/mcs_term.sv
`timescale 1ns/1ps
module mcs_term
    import mcs_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mcs_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic             trickle_n,
    output logic             term_n
);
    localparam logic [WIDTH-1:0] TOP = '1;

    always_comb begin
        case (op)
            OP_UP:     term_n = trickle_n | (cur != TOP);
            OP_DOWN:   term_n = trickle_n | (cur != '0);
            OP_TO_LSB,
            OP_TO_MSB: term_n = cur[WIDTH-1];
            default:   term_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/mode_counter_shifter.sv
`timescale 1ns/1ps
module mode_counter_shifter
    import mcs_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] preset,
    input  logic             par_en_n,
    input  logic             trickle_n,
    input  logic             ser_lsb,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_n,
    output logic             term_n
);
    localparam logic [WIDTH-1:0] TOP = '1;

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } mcs_state_s;

    mcs_state_s st_d, st_q;
    mcs_op_e    op;
    logic [WIDTH-1:0] nxt_val;

    assign op = mcs_op_e'(op_sel);

    mcs_next #(.WIDTH(WIDTH)) u_next (
        .op        (op),
        .cur       (st_q.val),
        .preset    (preset),
        .par_en_n  (par_en_n),
        .trickle_n (trickle_n),
        .ser_lsb   (ser_lsb),
        .nxt       (nxt_val)
    );

    mcs_term #(.WIDTH(WIDTH)) u_term (
        .op        (op),
        .cur       (st_q.val),
        .trickle_n (trickle_n),
        .term_n    (term_n)
    );

    always_comb begin
        st_d     = st_q;
        st_d.val = nxt_val;
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign q   = st_q.val;
    assign q_n = ~st_q.val;

    always @(posedge clk) begin
        if (mrst) assert_reset_clear_R2: assert (q == '0);
    end

    always_comb begin
        assert_inverse_out_R13: assert (mrst || (q_n ^ q) == TOP || $isunknown(q));
    end

    assert_hold_R12: assert property (@(posedge clk) disable iff (mrst)
        (op_sel == 3'd7) |=> $stable(q));

    assert_clear_R12: assert property (@(posedge clk) disable iff (mrst)
        (op_sel == 3'd5) |=> (q == '0));

    assert_invert_R4: assert property (@(posedge clk) disable iff (mrst)
        (op_sel == 3'd1) |=> (q == ~$past(q)));

    assert_count_gated_R8: assert property (@(posedge clk) disable iff (mrst)
        ((op_sel == 3'd4 || op_sel == 3'd6) && (par_en_n || trickle_n)) |=> $stable(q));

    assert_term_count_R9: assert property (@(posedge clk) disable iff (mrst)
        ((op_sel == 3'd6 || op_sel == 3'd4) && trickle_n) |-> term_n);

    assert_term_shift_R10: assert property (@(posedge clk) disable iff (mrst)
        (op_sel == 3'd2 || op_sel == 3'd3) |-> (term_n == q[WIDTH-1]));

    assert_term_idle_R11: assert property (@(posedge clk) disable iff (mrst)
        (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd5 || op_sel == 3'd7) |-> term_n);
endmodule

// File: tb/mode_counter_shifter_bench.sv
`timescale 1ns/1ps
module mode_counter_shifter_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic       mrst;
    logic [2:0] sel;
    logic [3:0] pre;
    logic       cep, cet, d3;
    logic [3:0] q, q_n;
    logic       tc;

    mode_counter_shifter u_mode_counter_shifter (
        .clk(clk), .mrst(mrst), .op_sel(sel), .preset(pre), .par_en_n(cep),
        .trickle_n(cet), .ser_lsb(d3), .q(q), .q_n(q_n), .term_n(tc));

    // two-stage cascade
    logic [2:0] c_sel;
    logic [7:0] c_pre;
    logic       c_cep, c_cet, c_d3;
    logic [3:0] lo_q, hi_q, lo_qn, hi_qn;
    logic       lo_tc, hi_tc;

    mode_counter_shifter u_cas_lo (
        .clk(clk), .mrst(mrst), .op_sel(c_sel), .preset(c_pre[3:0]), .par_en_n(c_cep),
        .trickle_n(c_cet), .ser_lsb(hi_q[0]), .q(lo_q), .q_n(lo_qn), .term_n(lo_tc));
    mode_counter_shifter u_cas_hi (
        .clk(clk), .mrst(mrst), .op_sel(c_sel), .preset(c_pre[7:4]), .par_en_n(c_cep),
        .trickle_n(lo_tc), .ser_lsb(c_d3), .q(hi_q), .q_n(hi_qn), .term_n(hi_tc));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_next(input logic [2:0] s, input logic [3:0] v,
            input logic [3:0] p, input logic en_p, input logic en_t, input logic sd);
        case (s)
            3'd0: return p;
            3'd1: return ~v;
            3'd2: return {sd, v[3:1]};
            3'd3: return {v[2:0], en_t};
            3'd4: return (!en_p && !en_t) ? v - 4'd1 : v;
            3'd5: return 4'd0;
            3'd6: return (!en_p && !en_t) ? v + 4'd1 : v;
            default: return v;
        endcase
    endfunction

    function automatic logic ref_tc(input logic [2:0] s, input logic [3:0] v, input logic en_t);
        case (s)
            3'd6: return !(!en_t && v == 4'hF);
            3'd4: return !(!en_t && v == 4'h0);
            3'd2, 3'd3: return v[3];
            default: return 1'b1;
        endcase
    endfunction

    function automatic string req_q(input logic [2:0] s, input logic en_p, input logic en_t);
        case (s)
            3'd0: return "R3 load";
            3'd1: return "R4 complement";
            3'd2: return "R5 shift to LSB";
            3'd3: return "R6 shift to MSB";
            3'd4, 3'd6: return (en_p || en_t) ? "R8 gated count" : "R7 count";
            3'd5: return "R12 clear";
            default: return "R12 hold";
        endcase
    endfunction

    function automatic string req_tc(input logic [2:0] s);
        case (s)
            3'd4, 3'd6: return "R9 count terminal";
            3'd2, 3'd3: return "R10 shift terminal";
            default: return "R11 idle terminal";
        endcase
    endfunction

    logic [3:0] mq;

    // Called at a negedge: checks terminal, clocks once, checks q/q_n (R1 decode throughout)
    task automatic step(input logic [2:0] s, input logic [3:0] p, input logic ep,
                        input logic et, input logic sd);
        sel = s; pre = p; cep = ep; cet = et; d3 = sd;
        #1;
        chk(req_tc(s), {7'd0, tc}, {7'd0, ref_tc(s, mq, et)});
        @(posedge clk);
        mq = ref_next(s, mq, p, ep, et, sd);
        @(negedge clk);
        chk(req_q(s, ep, et), {4'd0, q}, {4'd0, mq});
        chk("R13 inverse", {4'd0, q_n}, {4'd0, ~mq});
    endtask

    logic [7:0] cv;

    task automatic cstep(input logic [2:0] s, input logic [7:0] p, input logic et,
                         input logic sd, input string req);
        c_sel = s; c_pre = p; c_cep = 1'b0; c_cet = et; c_d3 = sd;
        #1;
        if (s == 3'd6) chk("R9 cascade carry", {7'd0, hi_tc}, {7'd0, !(cv == 8'hFF)});
        if (s == 3'd4) chk("R9 cascade borrow", {7'd0, hi_tc}, {7'd0, !(cv == 8'h00)});
        @(posedge clk);
        case (s)
            3'd0: cv = p;
            3'd2: cv = {sd, cv[7:1]};
            3'd3: cv = {cv[6:0], et};
            3'd4: cv = cv - 8'd1;
            3'd6: cv = cv + 8'd1;
            default: cv = cv;
        endcase
        @(negedge clk);
        chk(req, {hi_q, lo_q}, cv);
    endtask

    initial begin
        #(150000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20231));
        mrst = 1'b1; sel = 3'd7; pre = 4'h0; cep = 1'b1; cet = 1'b1; d3 = 1'b0;
        c_sel = 3'd7; c_pre = 8'h00; c_cep = 1'b1; c_cet = 1'b1; c_d3 = 1'b0;
        mq = 4'h0; cv = 8'h00;
        repeat (3) @(negedge clk);
        chk("R2 reset value", {4'd0, q}, 8'h00);
        chk("R13 reset inverse", {4'd0, q_n}, 8'h0F);
        mrst = 1'b0;

        // directed corners
        step(3'd0, 4'hF, 1, 1, 0);   // R3
        step(3'd6, 4'h0, 0, 0, 0);   // R7 up wrap 15->0, R9 tc low at 15
        step(3'd4, 4'h0, 0, 0, 0);   // R7 down wrap 0->15, R9
        step(3'd4, 4'h0, 0, 1, 0);   // R8 trickle off, R9 tc high
        step(3'd6, 4'h0, 1, 0, 0);   // R8 parallel off; R9 tc low despite par_en_n
        step(3'd2, 4'h0, 1, 1, 0);   // R5
        step(3'd3, 4'h0, 1, 1, 1);   // R6 serial 1
        step(3'd1, 4'h0, 1, 1, 0);   // R4
        step(3'd5, 4'h0, 1, 1, 0);   // R12 clear
        step(3'd7, 4'h0, 0, 0, 1);   // R12 hold

        // R2: asynchronous clear between edges
        step(3'd0, 4'hA, 1, 1, 0);
        #2 mrst = 1'b1;
        #1 chk("R2 async clear", {4'd0, q}, 8'h00);
        sel = 3'd0; pre = 4'h5;
        @(posedge clk); @(negedge clk);
        chk("R2 clock ignored under reset", {4'd0, q}, 8'h00);
        mrst = 1'b0; mq = 4'h0;

        // random sequence
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[2:0], r[6:3], r[7] & r[8], r[9] & r[10], r[11]);
        end

        // cascade: count up across the stage boundary
        cstep(3'd5, 8'h00, 1, 0, "R12 cascade clear");
        cv = 8'h00;
        for (int i = 0; i < 260; i++) cstep(3'd6, 8'h00, 0, 0, "R7 cascade up");
        cstep(3'd0, 8'h02, 1, 0, "R3 cascade load");
        for (int i = 0; i < 6; i++) cstep(3'd4, 8'h00, 0, 0, "R7 cascade down");
        cstep(3'd0, 8'h96, 1, 0, "R3 cascade load");
        for (int i = 0; i < 8; i++) cstep(3'd3, 8'h00, i[0], 0, "R6 cascade shift to MSB");
        for (int i = 0; i < 8; i++) cstep(3'd2, 8'h00, 1, i[1], "R5 cascade shift to LSB");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule